// File: doc/BRIEF.md
# PDM control-pattern detector

This block listens to one channel of a stereo PDM link and recognises command bytes that a transmitter sends in place of audio. The PDM clock and data lines are brought into the system clock domain through a synchroniser. On every transition of the PDM clock that belongs to the selected channel, one data bit is taken. The bits form a sliding byte window, MSB first. Once the window matches an entry of a parameterised command table, the detector locks to that byte alignment and checks every following byte against the same code.

A command counts as received only after a long run of identical, error-free bytes. A single bad bit breaks the run, and counting starts again from nothing. There are two kinds of table entry. A setting-type entry produces a one-cycle pulse and latches its code, which stays on the output after the pattern has gone. A hold-type entry, such as mute or power-down, drives a level output. That output stays high only while the pattern keeps arriving and drops at the first byte that does not match.

The channel-select input is a static strap. It chooses whether the rising or the falling PDM clock transition carries the channel being watched.

Top module: `pdm_cmd_detect`

## Requirements
- R1: With `chan_sel` = 0 the data line is sampled only on rising `pdm_clk` transitions, and with `chan_sel` = 1 only on falling ones. Bits on the other transition have no effect on any output.
- R2: Sampled bits enter the byte window MSB first with no gap bits between bytes. A command is found at any bit offset in the stream. While unlocked, the window is compared with every table code after each sampled bit. After a match, it is compared only once every 8 sampled bits.
- R3: A command takes effect at the end of its REPEATS-th consecutive matching byte (default 128, i.e. 1024 bits). After 127 bytes, no output has changed.
- R4: A byte boundary whose window differs from the locked code resets the run count to zero. If that window equals another table code, the count instead restarts at one for the new code.
- R5: When a setting-type entry completes its run, `cmd_pulse` is high for exactly one clock, and `cmd_code` takes that entry's code at the same edge. Further repeats of the same run do not pulse again. `cmd_code` keeps its value after the pattern stops.
- R6: A hold-type entry drives `hold_act[k]` (k = table index) high from the end of its run until the first byte boundary whose window does not match. It therefore falls within 8 sampled bits of the first wrong byte. At most one `hold_act` bit is high at a time.
- R7: Default table, by index: 0 = 0x66 hold (mute), 1 = 0x0F hold (power-down), 2 = 0x5A setting, 3 = 0xA3 setting. Setting entries never raise `hold_act`. When several codes match an unlocked window, the lowest index wins.
- R8: While `rst_n` is low (asynchronous, active low), `hold_act`, `cmd_pulse` and `cmd_code` are all zero.
- R9: When `pdm_clk` changes between clock edges, the effect of the sampled bit appears on the outputs at the fourth rising `clk` edge after the change. Outputs change only on edges that follow a sampled bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than twice the PDM clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdm_clk | input | 1 | PDM bit clock, asynchronous to `clk` |
| pdm_dat | input | 1 | PDM data, two channels interleaved on the two clock transitions |
| chan_sel | input | 1 | 0 watches rising transitions, 1 watches falling transitions |
| hold_act | output | NUM_CMDS | Level per table entry, high while a hold-type command is held |
| cmd_pulse | output | 1 | One-cycle strobe when a setting-type command completes |
| cmd_code | output | CODE_W | Code of the last completed setting-type command |

## Verification
The bench watches the hold output across the boundary between the 127th and 128th byte. A detector that counts one byte too many or too few would move that edge by a whole byte. A single flipped bit is placed mid-run, followed by exactly enough good bytes to finish only if the count restarted. A design that merely pauses the count would fire early there.

A decoy command runs on the unwatched channel in every scenario. Sampling on the wrong transition would then mute or pulse when it should not. Two setting codes are sent back to back to test relocking on a mismatching boundary. A long setting run that keeps going after completion would reveal a repeated pulse or a latched code that does not hold.

// File: rtl/pdm_cmd_pkg.sv
package pdm_cmd_pkg;

   typedef enum logic {
      KIND_SETTING = 1'b0,
      KIND_HOLD    = 1'b1
   } cmd_kind_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/pdm_edge_sampler.sv
module pdm_edge_sampler #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pdm_clk,
   input  logic pdm_dat,
   input  logic chan_sel,
   output logic bit_vld,
   output logic bit_val
);

   // each stage holds {clock, data} so both lines see equal delay
   logic [SYNC_STAGES-1:0][1:0] sync_q;
   logic                        clk_prev_q;
   logic                        clk_cur;
   logic                        rise_seen;
   logic                        fall_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q     <= '0;
         clk_prev_q <= 1'b0;
      end else begin
         sync_q     <= {sync_q[SYNC_STAGES-2:0], {pdm_clk, pdm_dat}};
         clk_prev_q <= sync_q[SYNC_STAGES-1][1];
      end
   end

   assign clk_cur   = sync_q[SYNC_STAGES-1][1];
   assign rise_seen = clk_cur & ~clk_prev_q;
   assign fall_seen = ~clk_cur & clk_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_vld <= 1'b0;
         bit_val <= 1'b0;
      end else begin
         bit_vld <= chan_sel ? fall_seen : rise_seen;
         bit_val <= sync_q[SYNC_STAGES-1][0];
      end
   end

endmodule

// File: rtl/pdm_bit_window.sv
module pdm_bit_window #(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_vld,
   input  logic              bit_val,
   output logic [CODE_W-1:0] win_next
);

   logic [CODE_W-1:0] win_q;

   // newest bit enters at the LSB, so the oldest bit of a byte ends at the MSB
   assign win_next = {win_q[CODE_W-2:0], bit_val};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       win_q <= '0;
      else if (bit_vld) win_q <= win_next;
   end

endmodule

// File: rtl/pdm_code_matcher.sv
module pdm_code_matcher #(
   parameter int                         CODE_W    = 8,
   parameter int                         NUM_CMDS  = 4,
   parameter logic [NUM_CMDS*CODE_W-1:0] CMD_CODES = '0,
   localparam int                        IDX_W     = pdm_cmd_pkg::idx_width(NUM_CMDS)
) (
   input  logic [CODE_W-1:0]   win,
   output logic [NUM_CMDS-1:0] hits,
   output logic                any_hit,
   output logic [IDX_W-1:0]    first_idx
);

   for (genvar k = 0; k < NUM_CMDS; k++) begin : g_cmp
      assign hits[k] = (win == CMD_CODES[k*CODE_W +: CODE_W]);
   end

   assign any_hit = |hits;

   // descending scan leaves the lowest matching index in place
   always_comb begin
      first_idx = '0;
      for (int k = NUM_CMDS - 1; k >= 0; k--) begin
         if (hits[k]) first_idx = IDX_W'(k);
      end
   end

endmodule

// File: rtl/pdm_run_tracker.sv
module pdm_run_tracker
   import pdm_cmd_pkg::*;
#(
   parameter int                         CODE_W    = 8,
   parameter int                         NUM_CMDS  = 4,
   parameter int                         REPEATS   = 128,
   parameter logic [NUM_CMDS*CODE_W-1:0] CMD_CODES = '0,
   parameter logic [NUM_CMDS-1:0]        HOLD_MASK = '0,
   localparam int                        IDX_W     = idx_width(NUM_CMDS),
   localparam int                        PH_W      = $clog2(CODE_W),
   localparam int                        RUN_W     = $clog2(REPEATS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bit_vld,
   input  logic [NUM_CMDS-1:0] hits,
   input  logic                any_hit,
   input  logic [IDX_W-1:0]    first_idx,
   output logic [NUM_CMDS-1:0] hold_act,
   output logic                cmd_pulse,
   output logic [CODE_W-1:0]   cmd_code
);

   localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(REPEATS);
   localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(REPEATS - 1);
   localparam logic [PH_W-1:0]  PH_END   = PH_W'(CODE_W - 1);

   logic              locked_q, locked_d;
   logic [IDX_W-1:0]  idx_q, idx_d;
   logic [PH_W-1:0]   phase_q, phase_d;
   logic [RUN_W-1:0]  run_q, run_d;
   logic              pulse_d;
   logic [CODE_W-1:0] code_q, code_d;
   cmd_kind_e         cur_kind;

   assign cur_kind = HOLD_MASK[idx_q] ? KIND_HOLD : KIND_SETTING;

   always_comb begin
      locked_d = locked_q;
      idx_d    = idx_q;
      phase_d  = phase_q;
      run_d    = run_q;
      pulse_d  = 1'b0;
      code_d   = code_q;
      if (bit_vld) begin
         if (locked_q && (phase_q != PH_END)) begin
            phase_d = phase_q + 1'b1;
         end else begin
            phase_d = '0;
            if (locked_q && hits[idx_q]) begin
               if (run_q != RUN_FULL) run_d = run_q + 1'b1;
               if ((run_q == RUN_LAST) && (cur_kind == KIND_SETTING)) begin
                  pulse_d = 1'b1;
                  code_d  = CMD_CODES[int'(idx_q)*CODE_W +: CODE_W];
               end
            end else if (any_hit) begin
               locked_d = 1'b1;
               idx_d    = first_idx;
               run_d    = RUN_W'(1);
            end else begin
               locked_d = 1'b0;
               run_d    = '0;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked_q  <= 1'b0;
         idx_q     <= '0;
         phase_q   <= '0;
         run_q     <= '0;
         cmd_pulse <= 1'b0;
         code_q    <= '0;
      end else begin
         locked_q  <= locked_d;
         idx_q     <= idx_d;
         phase_q   <= phase_d;
         run_q     <= run_d;
         cmd_pulse <= pulse_d;
         code_q    <= code_d;
      end
   end

   assign cmd_code = code_q;

   for (genvar k = 0; k < NUM_CMDS; k++) begin : g_hold
      if (HOLD_MASK[k]) begin : g_level
         assign hold_act[k] = locked_q && (run_q == RUN_FULL) && (idx_q == IDX_W'(k));
      end else begin : g_none
         assign hold_act[k] = 1'b0;
      end
   end

endmodule

// File: rtl/pdm_cmd_detect.sv
module pdm_cmd_detect #(
   parameter int                         CODE_W      = 8,
   parameter int                         NUM_CMDS    = 4,
   parameter int                         REPEATS     = 128,
   parameter int                         SYNC_STAGES = 2,
   parameter logic [NUM_CMDS*CODE_W-1:0] CMD_CODES   = {8'hA3, 8'h5A, 8'h0F, 8'h66},
   parameter logic [NUM_CMDS-1:0]        HOLD_MASK   = 4'b0011,
   localparam int                        IDX_W       = pdm_cmd_pkg::idx_width(NUM_CMDS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pdm_clk,
   input  logic                pdm_dat,
   input  logic                chan_sel,
   output logic [NUM_CMDS-1:0] hold_act,
   output logic                cmd_pulse,
   output logic [CODE_W-1:0]   cmd_code
);

   if (CODE_W < 2)      begin : g_bad_w   $error("CODE_W must be at least 2");      end
   if (NUM_CMDS < 1)    begin : g_bad_n   $error("NUM_CMDS must be at least 1");    end
   if (REPEATS < 2)     begin : g_bad_r   $error("REPEATS must be at least 2");     end
   if (SYNC_STAGES < 2) begin : g_bad_s   $error("SYNC_STAGES must be at least 2"); end

   logic                smp_vld;
   logic                smp_val;
   logic [CODE_W-1:0]   win_next;
   logic [NUM_CMDS-1:0] hits;
   logic                any_hit;
   logic [IDX_W-1:0]    first_idx;

   pdm_edge_sampler #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_sampler (
      .clk      (clk),
      .rst_n    (rst_n),
      .pdm_clk  (pdm_clk),
      .pdm_dat  (pdm_dat),
      .chan_sel (chan_sel),
      .bit_vld  (smp_vld),
      .bit_val  (smp_val)
   );

   pdm_bit_window #(
      .CODE_W (CODE_W)
   ) u_window (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_vld  (smp_vld),
      .bit_val  (smp_val),
      .win_next (win_next)
   );

   pdm_code_matcher #(
      .CODE_W    (CODE_W),
      .NUM_CMDS  (NUM_CMDS),
      .CMD_CODES (CMD_CODES)
   ) u_matcher (
      .win       (win_next),
      .hits      (hits),
      .any_hit   (any_hit),
      .first_idx (first_idx)
   );

   pdm_run_tracker #(
      .CODE_W    (CODE_W),
      .NUM_CMDS  (NUM_CMDS),
      .REPEATS   (REPEATS),
      .CMD_CODES (CMD_CODES),
      .HOLD_MASK (HOLD_MASK)
   ) u_tracker (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_vld   (smp_vld),
      .hits      (hits),
      .any_hit   (any_hit),
      .first_idx (first_idx),
      .hold_act  (hold_act),
      .cmd_pulse (cmd_pulse),
      .cmd_code  (cmd_code)
   );

endmodule

// File: rtl/pdm_cmd_detect_chk.sv
module pdm_cmd_detect_chk #(
   parameter int                  CODE_W    = 8,
   parameter int                  NUM_CMDS  = 4,
   parameter logic [NUM_CMDS-1:0] HOLD_MASK = '0
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bit_vld,
   input logic [NUM_CMDS-1:0] hold_act,
   input logic                cmd_pulse,
   input logic [CODE_W-1:0]   cmd_code
);

   p_setting_no_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_act & ~HOLD_MASK) == '0);

   p_hold_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hold_act));

   p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_pulse |=> !cmd_pulse);

   p_code_moves_with_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cmd_code) |-> cmd_pulse);

   p_no_pulse_while_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_pulse |-> (hold_act == '0));

   p_change_after_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_pulse || !$stable(hold_act)) |-> $past(bit_vld));

endmodule

bind pdm_cmd_detect pdm_cmd_detect_chk #(
   .CODE_W    (CODE_W),
   .NUM_CMDS  (NUM_CMDS),
   .HOLD_MASK (HOLD_MASK)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bit_vld   (smp_vld),
   .hold_act  (hold_act),
   .cmd_pulse (cmd_pulse),
   .cmd_code  (cmd_code)
);

// File: tb/tb_pdm_cmd_detect.sv
module tb_pdm_cmd_detect;

   localparam int NCMD = 4;
   localparam int RUNS = 128;
   localparam int LAT  = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            pdm_clk = 1'b0;
   logic            pdm_dat = 1'b0;
   logic            chan_sel = 1'b0;
   logic [NCMD-1:0] hold_act;
   logic            cmd_pulse;
   logic [7:0]      cmd_code;

   pdm_cmd_detect #(
      .CODE_W      (8),
      .NUM_CMDS    (NCMD),
      .REPEATS     (RUNS),
      .SYNC_STAGES (2),
      .CMD_CODES   ({8'hA3, 8'h5A, 8'h0F, 8'h66}),
      .HOLD_MASK   (4'b0011)
   ) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .pdm_clk   (pdm_clk),
      .pdm_dat   (pdm_dat),
      .chan_sel  (chan_sel),
      .hold_act  (hold_act),
      .cmd_pulse (cmd_pulse),
      .cmd_code  (cmd_code)
   );

   always #10 clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;
   bit live = 1'b0;

   // reference model state
   int codes[NCMD] = '{8'h66, 8'h0F, 8'h5A, 8'hA3};
   bit holds[NCMD] = '{1'b1, 1'b1, 1'b0, 1'b0};
   int q_cyc[$];
   bit q_bit[$];
   int m_win = 0, m_locked = 0, m_idx = 0, m_phase = 0, m_run = 0;
   int exp_hold = 0, exp_code = 0;
   bit exp_pulse = 1'b0;
   int seen_pulses = 0;

   task automatic check_eq(input int act, input int exp, input string req);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   function automatic void model_bit(input bit b);
      int prev_run;
      int found;
      prev_run = m_run;
      m_win = ((m_win << 1) | int'(b)) & 8'hFF;
      if (m_locked != 0 && m_phase != 7) begin
         m_phase++;
      end else begin
         m_phase = 0;
         if (m_locked != 0 && m_win == codes[m_idx]) begin
            if (m_run < RUNS) m_run++;
         end else begin
            found = -1;
            foreach (codes[k]) if (found < 0 && m_win == codes[k]) found = k;
            if (found >= 0) begin
               m_locked = 1; m_idx = found; m_run = 1;
            end else begin
               m_locked = 0; m_run = 0;
            end
         end
      end
      exp_hold = (m_run == RUNS && holds[m_idx]) ? (1 << m_idx) : 0;
      if (m_run == RUNS && prev_run == RUNS - 1 && !holds[m_idx]) begin
         exp_pulse = 1'b1;
         exp_code  = codes[m_idx];
      end
   endfunction

   always @(posedge clk) cyc <= cyc + 1;

   // per-clock comparison, away from the active edge
   always @(negedge clk) begin
      exp_pulse = 1'b0;
      while (q_cyc.size() > 0 && cyc >= q_cyc[0] + LAT) begin
         void'(q_cyc.pop_front());
         model_bit(q_bit.pop_front());
      end
      if (live) begin
         check_eq(int'(hold_act), exp_hold, "R6 hold level per clock");
         check_eq(int'(cmd_pulse), int'(exp_pulse), "R5 pulse per clock");
         check_eq(int'(cmd_code), exp_code, "R5 latched code per clock");
         if (cmd_pulse) seen_pulses++;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_pair(input bit lb, input bit rb);
      tick(1);
      pdm_dat = lb;
      tick(2);
      pdm_clk = 1'b1;
      if (!chan_sel) begin q_cyc.push_back(cyc); q_bit.push_back(lb); end
      tick(2);
      pdm_dat = rb;
      tick(2);
      pdm_clk = 1'b0;
      if (chan_sel) begin q_cyc.push_back(cyc); q_bit.push_back(rb); end
      tick(1);
   endtask

   // watched byte on the selected channel, decoy on the other one
   task automatic send_bytes(input logic [7:0] w, input logic [7:0] d, input int n);
      for (int r = 0; r < n; r++) begin
         for (int i = 7; i >= 0; i--) begin
            if (chan_sel) send_pair(d[i], w[i]);
            else          send_pair(w[i], d[i]);
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int base;
      tick(4);
      check_eq(int'(hold_act), 0, "R8 hold in reset");
      check_eq(int'(cmd_pulse), 0, "R8 pulse in reset");
      check_eq(int'(cmd_code), 0, "R8 code in reset");
      rst_n = 1'b1;
      live  = 1'b1;
      tick(3);

      // mute on rising transitions; decoy setting code on falling ones
      chan_sel = 1'b0;
      send_bytes(8'hFF, 8'hFF, 2);
      send_pair(1'b1, 1'b0); send_pair(1'b0, 1'b1); send_pair(1'b1, 1'b1);
      base = seen_pulses;
      send_bytes(8'h66, 8'h5A, RUNS - 1);
      tick(6);
      check_eq(int'(hold_act), 0, "R3 no mute after 127 bytes");
      send_bytes(8'h66, 8'h5A, 1);
      tick(6);
      check_eq(int'(hold_act), 1, "R3 R7 mute at 128th byte");
      send_bytes(8'h66, 8'h5A, 4);
      check_eq(int'(hold_act), 1, "R6 mute held while pattern repeats");
      check_eq(seen_pulses - base, 0, "R1 decoy on other transition ignored");
      send_bytes(8'hFF, 8'h5A, 1);
      tick(6);
      check_eq(int'(hold_act), 0, "R6 mute released within one byte");

      // setting code, kept running past completion
      base = seen_pulses;
      send_bytes(8'h5A, 8'h66, RUNS + 2);
      send_bytes(8'hFF, 8'h66, 3);
      tick(6);
      check_eq(seen_pulses - base, 1, "R5 one pulse per run");
      check_eq(int'(cmd_code), 8'h5A, "R5 code persists after pattern");
      check_eq(int'(hold_act), 0, "R1 R7 decoy mute ignored");

      // one flipped bit mid-run restarts the count
      base = seen_pulses;
      send_bytes(8'h5A, 8'hFF, 60);
      send_bytes(8'h5B, 8'hFF, 1);
      send_bytes(8'h5A, 8'hFF, RUNS - 1);
      tick(6);
      check_eq(seen_pulses - base, 0, "R4 bit error restarts run");
      send_bytes(8'h5A, 8'hFF, 1);
      tick(6);
      check_eq(seen_pulses - base, 1, "R4 R3 full run after error");

      // falling-transition channel: power-down, decoy mute on rising
      chan_sel = 1'b1;
      send_bytes(8'hFF, 8'h66, 2);
      send_bytes(8'h0F, 8'h66, RUNS);
      tick(6);
      check_eq(int'(hold_act), 2, "R1 R7 power-down on falling channel");
      send_bytes(8'hFF, 8'h66, 1);
      tick(6);
      check_eq(int'(hold_act), 0, "R6 power-down released");

      // two setting codes back to back: relock on the mismatching boundary
      base = seen_pulses;
      send_bytes(8'hA3, 8'hFF, RUNS);
      tick(6);
      check_eq(int'(cmd_code), 8'hA3, "R5 first setting code");
      send_bytes(8'h5A, 8'hFF, RUNS);
      tick(6);
      check_eq(seen_pulses - base, 2, "R4 R2 relock to next code");
      check_eq(int'(cmd_code), 8'h5A, "R5 second setting code");

      tick(8);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule